// File: doc/BRIEF.md
# Handshake Parallel Port with Edge-Flag Interrupts

This block is a single parallel I/O port as found in a peripheral interface adapter. Software reaches it through two bus addresses. The control address holds one control byte. The port address reaches either the output latch or the direction register, chosen by a select bit in the control byte. Each pin is an input or an output according to its direction bit. Reads of the port return live pin levels on input bits and the latched value on output bits.

Two handshake lines, C1 and C2, each pass through a synchronizer and then an edge detector. An edge of the polarity chosen in the control byte sets a sticky flag in that same byte. A flag drives the interrupt output when its enable bit is set. C2 can instead be turned into an output that drives a static level. In that mode its edges are ignored. A read of the data register acknowledges both flags.

Top module: `pio_edge_port`

## Requirements
- R1: After reset the control byte, the direction register and the output latch are all zero; `irq`, `pin_oe`, `pin_out` and `c2_oe` are low.
- R2: `bus_addr` = 1 selects the control byte. `bus_addr` = 0 selects the output latch when control bit 2 is 1 and the direction register when control bit 2 is 0. This applies to both reads and writes.
- R3: A read of the output latch returns `pin_in` on bits whose direction bit is 0 and the latch on bits whose direction bit is 1.
- R4: `pin_oe` equals the direction register and `pin_out` equals latch AND direction register.
- R5: A C1 transition sets control bit 7 when it matches control bit 1 (1 = rising, 0 = falling). A transition of the other polarity sets nothing. The flag is visible in the third clock cycle after the line changes.
- R6: While control bit 5 is 0 (C2 is an input), a C2 transition that matches control bit 4 (1 = rising, 0 = falling) sets control bit 6. While control bit 5 is 1, C2 transitions set no flag.
- R7: `irq` is high exactly while (bit 7 AND bit 0) OR (bit 6 AND bit 3) holds in the control byte. A flag that was set while its enable was 0 raises `irq` as soon as the enable is written to 1.
- R8: A read of the output latch clears bits 7 and 6. A read of the direction register does not. A bus write to the control byte changes only bits 5..0 and leaves bits 7 and 6 as they were.
- R9: A line level that is present across reset produces no flag, whatever polarity is selected right after reset. Edge detection compares only samples that were taken after reset.
- R10: While control bit 5 is 1, `c2_oe` is high and `c2_out` follows control bit 3. While control bit 5 is 0, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = port address, 1 = control address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational on the address) |
| pin_in | input | DATA_W | Pin levels seen from outside |
| pin_out | output | DATA_W | Pin drive value |
| pin_oe | output | DATA_W | Per-pin output enable |
| c1_in | input | 1 | Handshake line C1 |
| c2_in | input | 1 | Handshake line C2 when used as an input |
| c2_out | output | 1 | C2 static drive level |
| c2_oe | output | 1 | C2 output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is the one in R9. A handshake line sits high through reset and rising polarity is chosen in the very first cycle after release. This happens while the synchronizer still holds its reset zeros. A detector that trusted those zeros would report a false rising edge. To create this case, the bench releases reset on a falling clock edge and places a control write on the bus in the same half cycle. It then waits and confirms that no flag appears. Finally it drops and raises the line again, which shows that real edges are still caught after the warm-up.

// File: rtl/pio_pkg.sv
package pio_pkg;
   // control byte bit positions (software decodes these)
   localparam int CB_C1_FLAG = 7;
   localparam int CB_C2_FLAG = 6;
   localparam int CB_C2_DIR  = 5;   // 1 = C2 output
   localparam int CB_C2_POL  = 4;   // 1 = rising
   localparam int CB_C2_IE   = 3;   // also C2 drive level in output mode
   localparam int CB_SEL     = 2;   // 1 = latch, 0 = direction register
   localparam int CB_C1_POL  = 1;   // 1 = rising
   localparam int CB_C1_IE   = 0;
   localparam int CTRL_W     = 8;
   localparam int N_LINES    = 2;

   typedef enum logic {
      ADDR_PORT = 1'b0,
      ADDR_CTRL = 1'b1
   } port_addr_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pio_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pio_edge_det.sv
module pio_edge_det #(
   parameter int WARMUP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic rise_sel,
   input  logic arm,
   output logic hit
);
   logic              prev_q;
   logic [WARMUP-1:0] fill_q;

   generate
      if (WARMUP < 2) begin : g_bad_warmup
         $error("pio_edge_det: WARMUP must be at least 2");
      end
   endgenerate

   // prev_q tracks the line even while disarmed, so arming never sees a stale edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         fill_q <= '0;
      end else begin
         prev_q <= level;
         fill_q <= {fill_q[WARMUP-2:0], 1'b1};
      end
   end

   assign hit = fill_q[WARMUP-1] & arm & (level ^ prev_q) & (level == rise_sel);
endmodule

// File: rtl/pio_dir_mux.sv
module pio_dir_mux #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] ddr,
   input  logic [DATA_W-1:0] latch,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] port_view,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe
);
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign port_view[b] = ddr[b] ? latch[b] : pin_in[b];
         assign pin_out[b]   = ddr[b] & latch[b];
         assign pin_oe[b]    = ddr[b];
      end
   endgenerate
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe,
   input  logic              c1_in,
   input  logic              c2_in,
   output logic              c2_out,
   output logic              c2_oe,
   output logic              irq
);
   import pio_pkg::*;

   localparam int WARMUP = SYNC_STAGES + 1;

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("pio_edge_port: DATA_W must be at least 8");
      end
      if (SYNC_STAGES > 64) begin : g_bad_sync
         $error("pio_edge_port: SYNC_STAGES unreasonably large");
      end
   endgenerate

   logic [CTRL_W-1:0]  ctrl_q;
   logic [DATA_W-1:0]  ddr_q;
   logic [DATA_W-1:0]  latch_q;
   logic [DATA_W-1:0]  port_view;
   logic [N_LINES-1:0] line_raw;
   logic [N_LINES-1:0] line_sync;
   logic [N_LINES-1:0] rise_sel;
   logic [N_LINES-1:0] arm;
   logic [N_LINES-1:0] edge_hit;
   logic               wr_ctrl;
   logic               wr_port;
   logic               rd_latch;

   // line 0 = C1, line 1 = C2
   assign line_raw = {c2_in, c1_in};
   assign rise_sel = {ctrl_q[CB_C2_POL], ctrl_q[CB_C1_POL]};
   assign arm      = {~ctrl_q[CB_C2_DIR], 1'b1};

   pio_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (line_raw),
      .q_out (line_sync)
   );

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         pio_edge_det #(.WARMUP(WARMUP)) det_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (line_sync[i]),
            .rise_sel (rise_sel[i]),
            .arm      (arm[i]),
            .hit      (edge_hit[i])
         );
      end
   endgenerate

   assign wr_ctrl  = bus_cs & bus_we & (bus_addr == ADDR_CTRL);
   assign wr_port  = bus_cs & bus_we & (bus_addr == ADDR_PORT);
   assign rd_latch = bus_cs & ~bus_we & (bus_addr == ADDR_PORT) & ctrl_q[CB_SEL];

   // writable control bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q[CB_C2_DIR:0] <= '0;
      else if (wr_ctrl) ctrl_q[CB_C2_DIR:0] <= bus_wdata[CB_C2_DIR:0];
   end

   // sticky edge flags: a new edge wins over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q[CB_C1_FLAG] <= 1'b0;
         ctrl_q[CB_C2_FLAG] <= 1'b0;
      end else begin
         if (edge_hit[0])   ctrl_q[CB_C1_FLAG] <= 1'b1;
         else if (rd_latch) ctrl_q[CB_C1_FLAG] <= 1'b0;
         if (edge_hit[1])   ctrl_q[CB_C2_FLAG] <= 1'b1;
         else if (rd_latch) ctrl_q[CB_C2_FLAG] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ddr_q   <= '0;
         latch_q <= '0;
      end else if (wr_port) begin
         if (ctrl_q[CB_SEL]) latch_q <= bus_wdata;
         else                ddr_q   <= bus_wdata;
      end
   end

   pio_dir_mux #(.DATA_W(DATA_W)) mux_i (
      .ddr       (ddr_q),
      .latch     (latch_q),
      .pin_in    (pin_in),
      .port_view (port_view),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_CTRL)  bus_rdata[CTRL_W-1:0] = ctrl_q;
      else if (ctrl_q[CB_SEL])    bus_rdata = port_view;
      else                        bus_rdata = ddr_q;
   end

   assign irq    = (ctrl_q[CB_C1_FLAG] & ctrl_q[CB_C1_IE]) |
                   (ctrl_q[CB_C2_FLAG] & ctrl_q[CB_C2_IE]);
   assign c2_oe  = ctrl_q[CB_C2_DIR];
   assign c2_out = ctrl_q[CB_C2_DIR] & ctrl_q[CB_C2_IE];
endmodule

// File: rtl/pio_edge_port_chk.sv
module pio_edge_port_chk #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_cs,
   input logic              bus_we,
   input logic              bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [7:0]        ctrl_q,
   input logic [DATA_W-1:0] ddr_q,
   input logic [1:0]        edge_hit,
   input logic              irq,
   input logic [DATA_W-1:0] pin_out,
   input logic [DATA_W-1:0] pin_oe
);
   localparam int WARM = SYNC_STAGES + 1;

   logic [7:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  since_rst <= '0;
      else if (since_rst != 8'hFF) since_rst <= since_rst + 8'd1;
   end

   // R2: direction register takes the written value when the select bit is 0
   assert_ddr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_we && !bus_addr && !ctrl_q[2]) |=> (ddr_q == $past(bus_wdata)));

   // R4: no pin is driven high unless it is enabled
   assert_pin_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

   // R6: a C2 flag appears only if C2 was an input in the setting cycle
   assert_c2_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q[6]) |-> !$past(ctrl_q[5]));

   // R7: interrupt can only rise with an enable set
   assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (ctrl_q[0] || ctrl_q[3]));

   // R8: control writes leave the flags alone
   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_we && bus_addr && (edge_hit == 2'b00)) |=> (ctrl_q[7:6] == $past(ctrl_q[7:6])));

   // R8: a latch read acknowledges both flags
   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && !bus_we && !bus_addr && ctrl_q[2] && (edge_hit == 2'b00)) |=> (ctrl_q[7:6] == 2'b00));

   // R9: no flag during the warm-up after reset
   assert_no_early_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst <= 8'(WARM)) |-> (ctrl_q[7:6] == 2'b00));
endmodule

bind pio_edge_port pio_edge_port_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cs    (bus_cs),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ctrl_q    (ctrl_q),
   .ddr_q     (ddr_q),
   .edge_hit  (edge_hit),
   .irq       (irq),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/pio_edge_port_tb_top.sv
module pio_edge_port_tb_top;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_cs = 1'b0;
   logic          bus_we = 1'b0;
   logic          bus_addr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [DW-1:0] pin_in = '0;
   logic [DW-1:0] pin_out;
   logic [DW-1:0] pin_oe;
   logic          c1_in = 1'b0;
   logic          c2_in = 1'b0;
   logic          c2_out;
   logic          c2_oe;
   logic          irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   pio_edge_port #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
      .clk, .rst_n, .bus_cs, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .pin_in, .pin_out, .pin_oe, .c1_in, .c2_in, .c2_out, .c2_oe, .irq
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_cs = 1'b0;
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_c1(input logic v);
      @(negedge clk); c1_in = v; wait_clks(4);
   endtask

   task automatic set_c2(input logic v);
      @(negedge clk); c2_in = v; wait_clks(4);
   endtask

   task automatic t_reset_state;
      logic [DW-1:0] d;
      c1_in = 1'b0; c2_in = 1'b0; rst_n = 1'b0;
      wait_clks(3);
      rst_n = 1'b1;
      wait_clks(1);
      check("R1 irq", irq, 0);
      check("R1 pin_oe", pin_oe, 0);
      check("R1 pin_out", pin_out, 0);
      check("R1 c2_oe", c2_oe, 0);
      rd(1'b1, d); check("R1 ctrl", d, 8'h00);
      rd(1'b0, d); check("R1 ddr", d, 8'h00);
   endtask

   // R9: line high across reset, rising polarity written on the first cycle after release
   task automatic t_reset_high_lines;
      logic [DW-1:0] d;
      c1_in = 1'b1; c2_in = 1'b1; rst_n = 1'b0;
      wait_clks(3);
      rst_n = 1'b1;
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h12;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
      wait_clks(6);
      rd(1'b1, d); check("R9 no flag from reset level", d, 8'h12);
      set_c1(1'b0);
      set_c1(1'b1);
      rd(1'b1, d); check("R9 later edge still seen", d, 8'h92);
      set_c2(1'b0);
      set_c2(1'b1);
      rd(1'b1, d); check("R9 later C2 edge seen", d, 8'hD2);
      c1_in = 1'b0; c2_in = 1'b0;
      wr(1'b1, 8'h04);
      wait_clks(5);
      rd(1'b0, d);   // acknowledge
      rd(1'b1, d); check("R8 ack after R9 test", d, 8'h04);
   endtask

   task automatic t_dir_data;
      logic [DW-1:0] d;
      wr(1'b1, 8'h00);
      wr(1'b0, 8'hF0);
      rd(1'b0, d); check("R2 ddr readback", d, 8'hF0);
      check("R4 oe from ddr", pin_oe, 8'hF0);
      wr(1'b1, 8'h04);
      wr(1'b0, 8'hA5);
      check("R4 pin_out mask hi", pin_out, 8'hA0);
      pin_in = 8'h3C;
      rd(1'b0, d); check("R3 mixed read hi", d, 8'hAC);
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h0F);
      rd(1'b0, d); check("R2 ddr second", d, 8'h0F);
      wr(1'b1, 8'h04);
      check("R4 pin_out mask lo", pin_out, 8'h05);
      rd(1'b0, d); check("R3 mixed read lo", d, 8'h35);
      rd(1'b1, d); check("R2 ctrl addr", d, 8'h04);
   endtask

   task automatic t_c1_edges;
      logic [DW-1:0] d;
      wr(1'b1, 8'h07);
      set_c1(1'b1);
      rd(1'b1, d); check("R5 rising sets flag", d, 8'h87);
      check("R7 irq on C1", irq, 1);
      rd(1'b0, d);
      rd(1'b1, d); check("R8 latch read clears", d, 8'h07);
      check("R7 irq drops", irq, 0);
      set_c1(1'b0);
      rd(1'b1, d); check("R5 falling ignored in rising mode", d, 8'h07);
      wr(1'b1, 8'h05);
      set_c1(1'b1);
      rd(1'b1, d); check("R5 rising ignored in falling mode", d, 8'h05);
      set_c1(1'b0);
      rd(1'b1, d); check("R5 falling sets flag", d, 8'h85);
      rd(1'b0, d);
   endtask

   task automatic t_c2_edges;
      logic [DW-1:0] d;
      wr(1'b1, 8'h1C);
      set_c2(1'b1);
      rd(1'b1, d); check("R6 C2 rising sets flag", d, 8'h5C);
      check("R7 irq on C2", irq, 1);
      rd(1'b0, d);
      wr(1'b1, 8'h3C);
      check("R10 c2_oe", c2_oe, 1);
      check("R10 c2_out high", c2_out, 1);
      set_c2(1'b0);
      set_c2(1'b1);
      rd(1'b1, d); check("R6 output mode ignores edges", d, 8'h3C);
      check("R6 no irq in output mode", irq, 0);
      wr(1'b1, 8'h34);
      check("R10 c2_out low", c2_out, 0);
      wr(1'b1, 8'h1C);
      check("R10 c2_oe off", c2_oe, 0);
      rd(1'b1, d); check("R6 switching to input no stale edge", d, 8'h1C);
   endtask

   task automatic t_irq_mask;
      logic [DW-1:0] d;
      wr(1'b1, 8'h06);
      set_c1(1'b1);
      rd(1'b1, d); check("R7 flag without enable", d, 8'h86);
      check("R7 irq masked", irq, 0);
      wr(1'b1, 8'h07);
      rd(1'b1, d); check("R8 ctrl write keeps flag", d, 8'h87);
      check("R7 late enable raises irq", irq, 1);
      wr(1'b1, 8'h03);
      rd(1'b0, d);   // direction register read: no acknowledge
      rd(1'b1, d); check("R8 ddr read keeps flag", d, 8'h83);
      wr(1'b1, 8'h07);
      rd(1'b0, d);
      wr(1'b1, 8'hC4);
      rd(1'b1, d); check("R8 write cannot set flags", d, 8'h04);
      check("R7 irq low", irq, 0);
   endtask

   initial begin
      t_reset_state();
      t_reset_high_lines();
      t_dir_data();
      t_c1_edges();
      t_c2_edges();
      t_irq_mask();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog (R1..) got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule